// File: doc/BRIEF.md
# Hebbian Ternary Synapse Weight

This block is a clocked digital model of a single adaptive synapse. It keeps an unsigned fixed-point resistance in the range 0.0 to just under 1.0 (Q0.16). At each update strobe it applies a correlation rule to that value. When the input side and the output side both fire, the resistance falls by a small step and the connection gets stronger. When only the input side fires, the resistance rises and the connection gets weaker. When the input side is silent, nothing changes.

The stored value is also reported as a balanced-ternary weight. A low resistance reads as excitatory (+1), a high resistance as inhibitory (-1), and the middle band as neutral (0). The trit uses a 2-bit two's-complement encoding: 2'b01 = +1, 2'b00 = 0, 2'b11 = -1. The code 2'b10 is never produced. A surrounding reflex circuit samples the trit to weight its decision, and it strobes an update whenever the reflex is evaluated.

Top module: `hebb_synapse`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `res_q` equals 32768 (0.5) and `trit` is 2'b00.
- R2: An update with `pre_act`=1 and `post_act`=1 lowers `res_q` by 66. The new value appears one clock edge after the update is sampled.
- R3: An update with `pre_act`=1 and `post_act`=0 raises `res_q` by 66. The new value appears one clock edge after the update is sampled.
- R4: `res_q` keeps its value when `upd` is 0, or when `pre_act` is 0 whatever `post_act` is.
- R5: A lowering update whose result would go below 0 leaves `res_q` at 0. The value never wraps.
- R6: A raising update whose result would go above 65535 leaves `res_q` at 65535. The value never wraps.
- R7: `trit` is 2'b01 (+1) whenever `res_q` < 21627.
- R8: `trit` is 2'b11 (-1) whenever `res_q` > 43254.
- R9: `trit` is 2'b00 (0) whenever 21627 <= `res_q` <= 43254. The code 2'b10 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| upd | input | 1 | Update strobe |
| pre_act | input | 1 | Presynaptic activity bit |
| post_act | input | 1 | Postsynaptic activity bit |
| res_q | output | 16 | Registered resistance, unsigned Q0.16 |
| trit | output | 2 | Ternary weight: 01 = +1, 00 = 0, 11 = -1 |

## Verification
Each update changes `res_q` exactly one rising edge after the strobe is sampled. `trit` follows in the same cycle, because it is combinational from the register. The bench drives inputs on the falling edge and compares both outputs against a requirement-derived model on the following falling edge, so every comparison falls exactly one register stage after its stimulus. Long walks toward both ends step through the zone limits and into saturation, with a check after every single update.

// File: rtl/hebb_synapse.sv
module hebb_synapse #(
  parameter int unsigned W       = 16,
  parameter int unsigned STEP    = 66,
  parameter int unsigned EXC_LIM = 21627,
  parameter int unsigned INH_LIM = 43254
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         upd,
  input  logic         pre_act,
  input  logic         post_act,
  output logic [W-1:0] res_q,
  output logic [1:0]   trit
);

  localparam logic [W-1:0] MID  = W'(1) << (W - 1);
  localparam logic [W-1:0] TOP  = '1;
  localparam logic [W-1:0] STP  = W'(STEP);
  localparam logic [W-1:0] ELIM = W'(EXC_LIM);
  localparam logic [W-1:0] ILIM = W'(INH_LIM);

  logic         learn;
  logic [W-1:0] dec_v, inc_v;

  assign learn = upd && pre_act;
  assign dec_v = (res_q < STP)       ? '0  : res_q - STP;
  assign inc_v = (res_q > TOP - STP) ? TOP : res_q + STP;

  always_ff @(posedge clk) begin
    if (!rst_n)
      res_q <= MID;
    else if (learn)
      res_q <= post_act ? dec_v : inc_v;
  end

  assign trit = (res_q < ELIM) ? 2'b01 :
                (res_q > ILIM) ? 2'b11 : 2'b00;

  // R1
  a_r1_reset_mid: assert property (@(posedge clk)
    !rst_n |=> (res_q == MID));

  // R2
  a_r2_strengthen: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pre_act && post_act && res_q >= STP) |=> (res_q == $past(res_q) - STP));

  // R3
  a_r3_weaken: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pre_act && !post_act && res_q <= TOP - STP) |=> (res_q == $past(res_q) + STP));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(upd && pre_act) |=> $stable(res_q));

  // R5
  a_r5_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pre_act && post_act && res_q < STP) |=> (res_q == '0));

  // R6
  a_r6_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && pre_act && !post_act && res_q > TOP - STP) |=> (res_q == TOP));

  // R9
  a_r9_no_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    trit != 2'b10);

endmodule

// File: tb/sim_hebb_synapse.sv
module sim_hebb_synapse;
  localparam time CLK_PER = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd = 1'b0, pre_act = 1'b0, post_act = 1'b0;
  logic [15:0] res_q;
  logic [1:0]  trit;

  int n_cmp = 0;
  int n_bad = 0;
  int model = 32768;
  bit done = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  hebb_synapse u0 (.clk(clk), .rst_n(rst_n), .upd(upd), .pre_act(pre_act),
                   .post_act(post_act), .res_q(res_q), .trit(trit));

  function automatic logic [1:0] exp_trit(int r);
    if (r < 21627) return 2'b01;
    if (r > 43254) return 2'b11;
    return 2'b00;
  endfunction

  task automatic check(string req);
    logic [1:0] et;
    et = exp_trit(model);
    n_cmp++;
    if (res_q !== model[15:0] || trit !== et) begin
      n_bad++;
      $display("FAIL %s: res_q=%0d trit=%b expected res_q=%0d trit=%b", req, res_q, trit, model, et);
    end
  endtask

  task automatic step(bit u, bit p, bit q, string req);
    @(negedge clk);
    upd = u; pre_act = p; post_act = q;
    if (u && p) begin
      if (q) model = (model - 66 < 0) ? 0 : model - 66;
      else   model = (model + 66 > 65535) ? 65535 : model + 66;
    end
    @(negedge clk);
    upd = 1'b0; pre_act = 1'b0; post_act = 1'b0;
    check(req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    model = 32768;
    check("R1");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
  endtask

  task automatic t_single;
    step(1, 1, 1, "R2");
    step(1, 1, 0, "R3");
    step(1, 1, 0, "R3");
    step(1, 1, 1, "R2");
  endtask

  task automatic t_hold;
    step(1, 0, 1, "R4");
    step(1, 0, 0, "R4");
    step(0, 1, 1, "R4");
    step(0, 1, 0, "R4");
    step(0, 0, 1, "R4");
  endtask

  task automatic t_floor;
    for (int i = 0; i < 520; i++) step(1, 1, 1, (model < 21627) ? "R7" : "R9");
    step(1, 1, 1, "R5");
    if (model != 0) begin n_bad++; $display("FAIL R5: model=%0d expected 0", model); end
  endtask

  task automatic t_ceiling;
    for (int i = 0; i < 1000; i++) step(1, 1, 0, (model > 43254) ? "R8" : "R9");
    step(1, 1, 0, "R6");
    step(1, 0, 1, "R4");
  endtask

  task automatic t_return;
    for (int i = 0; i < 500; i++) step(1, 1, 1, "R9");
    t_reset();
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_single();
    t_hold();
    t_floor();
    t_ceiling();
    t_return();
    finish_run();
  end

  initial begin
    #(CLK_PER * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    finish_run();
  end
endmodule